// File: doc/BRIEF.md
# General Register File with Aliased Narrow Views

This block holds eight 32-bit general registers and lets every access name a register by a 3-bit code plus an access size. Codes 0 to 3 are the data registers and codes 4 to 7 are the pointer/index registers. At word size, any code reaches bits 15:0 of its register. At byte size, only the four data registers can be reached. Byte codes 0 to 3 select bits 7:0 of registers 0 to 3, and byte codes 4 to 7 select bits 15:8 of registers 0 to 3. Dword size reaches the whole register. All views share storage, so a narrow write changes only its slice of the 32-bit register.

There is one write port, driven by an operation. A move copies the second operand into the destination view. An add or subtract combines the destination view with the second operand and writes the result back at the selected width, wrapping modulo 2^size. The second operand is either a source register view of the same size or an immediate. Two independent combinational read ports return any view, zero-extended to 32 bits.

Top module: `gpr_regfile_alias`

## Requirements
- R1: After reset, every register reads 0 at every size.
- R2: A legal dword write (size code 2) replaces all 32 bits of the destination register.
- R3: A legal word write (size code 1) to any code 0..7 replaces bits 15:0 of that register and leaves bits 31:16 unchanged.
- R4: A legal byte write (size code 0) with code 0..3 replaces bits 7:0 of register 0..3 and leaves bits 31:8 unchanged.
- R5: A legal byte write with code 4..7 replaces bits 15:8 of register code-4 and leaves bits 31:16 and 7:0 unchanged.
- R6: Each read port returns the view selected by its code and size, zero-extended to 32 bits, using the same code mapping as writes. Size code 3 reads as 0. The two ports are independent.
- R7: A read of a register that is written in the same cycle returns the old value. The new value is visible after the clock edge.
- R8: Op code 0 moves, op code 1 adds and op code 2 subtracts. The second operand is the immediate (low size bits) when use_imm_i is 1, and otherwise the source view of the same size. The result wraps modulo 2^size and only the selected slice is written.
- R9: An operation with size code 3 or op code 3 raises illegal_o in the same cycle and writes nothing.
- R10: With we_i low, no register changes and illegal_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Execute the operation this cycle |
| op_i | input | 2 | 0 move, 1 add, 2 subtract, 3 reserved |
| size_i | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| dst_code_i | input | 3 | Destination view code, which is also the first operand |
| src_code_i | input | 3 | Source view code for the second operand |
| use_imm_i | input | 1 | Second operand comes from imm_i |
| imm_i | input | 32 | Immediate operand |
| illegal_o | output | 1 | Requested operation is illegal and not written |
| rd_a_code_i | input | 3 | Read port A code |
| rd_a_size_i | input | 2 | Read port A size |
| rd_a_data_o | output | 32 | Read port A data, zero-extended |
| rd_b_code_i | input | 3 | Read port B code |
| rd_b_size_i | input | 2 | Read port B size |
| rd_b_data_o | output | 32 | Read port B data, zero-extended |

## Verification
The hardest case to reach is a high-byte operation whose source and destination alias the same 32-bit register through different views. An example is an add of byte code 4 into byte code 0, while a read port watches that register at dword size in the same cycle. This single case shows whether the operand extract, the slice merge and the old-value read all line up. Directed steps set up such aliased pairs with distinct byte patterns in every slice, so any bleed into a neighbouring slice is visible. A long stretch of mixed random operations, including reserved codes, is then compared every clock against a behavioural model.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned XLEN_DEF = 32;
  localparam int unsigned NREG_DEF = 8;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_RSVD = 2'd3} size_e;
  typedef enum logic [1:0] {OP_MOV = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_RSVD = 2'd3} op_e;

  function automatic logic [XLEN_DEF-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE:  size_mask = XLEN_DEF'(32'h0000_00ff);
      SZ_WORD:  size_mask = XLEN_DEF'(32'h0000_ffff);
      SZ_DWORD: size_mask = '1;
      default:  size_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/gpr_view_rd.sv
module gpr_view_rd
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF,
  parameter int unsigned NREG = NREG_DEF,
  localparam int unsigned CW = $clog2(NREG),
  localparam int unsigned HW = XLEN / 2,
  localparam int unsigned BW = XLEN / 4
) (
  input  logic [NREG-1:0][XLEN-1:0] regs_i,
  input  logic [CW-1:0]             code_i,
  input  logic [1:0]                size_i,
  output logic [XLEN-1:0]           data_o
);
  logic [CW-1:0]   byte_idx;
  logic [XLEN-1:0] byte_reg;

  // byte codes fold onto the lower half of the register set
  assign byte_idx = {1'b0, code_i[CW-2:0]};
  assign byte_reg = regs_i[byte_idx];

  always_comb begin
    data_o = '0;
    case (size_e'(size_i))
      SZ_BYTE:  data_o[BW-1:0] = code_i[CW-1] ? byte_reg[2*BW-1:BW] : byte_reg[BW-1:0];
      SZ_WORD:  data_o[HW-1:0] = regs_i[code_i][HW-1:0];
      SZ_DWORD: data_o         = regs_i[code_i];
      default:  data_o         = '0;
    endcase
  end
endmodule

// File: rtl/gpr_alu.sv
module gpr_alu
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      size_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] raw;

  always_comb begin
    case (op_e'(op_i))
      OP_ADD:  raw = a_i + b_i;
      OP_SUB:  raw = a_i - b_i;
      default: raw = b_i;
    endcase
  end

  // wrap at the selected width
  assign res_o = raw & size_mask(size_i);
endmodule

// File: rtl/gpr_view_wr.sv
module gpr_view_wr
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF,
  localparam int unsigned HW = XLEN / 2,
  localparam int unsigned BW = XLEN / 4
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] val_i,
  input  logic [1:0]      size_i,
  input  logic            hi_i,
  output logic [XLEN-1:0] merged_o
);
  always_comb begin
    merged_o = old_i;
    case (size_e'(size_i))
      SZ_BYTE: begin
        if (hi_i) merged_o[2*BW-1:BW] = val_i[BW-1:0];
        else      merged_o[BW-1:0]    = val_i[BW-1:0];
      end
      SZ_WORD:  merged_o[HW-1:0] = val_i[HW-1:0];
      SZ_DWORD: merged_o         = val_i;
      default:  merged_o         = old_i;
    endcase
  end
endmodule

// File: rtl/gpr_regfile_alias.sv
module gpr_regfile_alias
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF,
  parameter int unsigned NREG = NREG_DEF,
  localparam int unsigned CW = $clog2(NREG),
  localparam int unsigned NVIEW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      size_i,
  input  logic [CW-1:0]   dst_code_i,
  input  logic [CW-1:0]   src_code_i,
  input  logic            use_imm_i,
  input  logic [XLEN-1:0] imm_i,
  output logic            illegal_o,
  input  logic [CW-1:0]   rd_a_code_i,
  input  logic [1:0]      rd_a_size_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [CW-1:0]   rd_b_code_i,
  input  logic [1:0]      rd_b_size_i,
  output logic [XLEN-1:0] rd_b_data_o
);
  logic [NREG-1:0][XLEN-1:0] regs_q;
  logic [NVIEW-1:0][CW-1:0]  view_code;
  logic [NVIEW-1:0][1:0]     view_size;
  logic [NVIEW-1:0][XLEN-1:0] view_data;

  logic            legal, do_wr, hi_sel;
  logic [CW-1:0]   tgt_idx;
  logic [XLEN-1:0] opnd_b, alu_res, merged;

  // views: 0/1 external read ports, 2 destination operand, 3 source operand
  assign view_code = {src_code_i, dst_code_i, rd_b_code_i, rd_a_code_i};
  assign view_size = {size_i, size_i, rd_b_size_i, rd_a_size_i};

  for (genvar v = 0; v < NVIEW; v++) begin : g_view
    gpr_view_rd #(.XLEN(XLEN), .NREG(NREG)) u_view (
      .regs_i (regs_q),
      .code_i (view_code[v]),
      .size_i (view_size[v]),
      .data_o (view_data[v])
    );
  end

  assign rd_a_data_o = view_data[0];
  assign rd_b_data_o = view_data[1];

  assign legal     = (size_e'(size_i) != SZ_RSVD) && (op_e'(op_i) != OP_RSVD);
  assign do_wr     = we_i && legal;
  assign illegal_o = we_i && !legal;

  assign opnd_b = use_imm_i ? (imm_i & size_mask(size_i)) : view_data[3];

  gpr_alu #(.XLEN(XLEN)) u_alu (
    .a_i    (view_data[2]),
    .b_i    (opnd_b),
    .op_i   (op_i),
    .size_i (size_i),
    .res_o  (alu_res)
  );

  assign hi_sel  = (size_e'(size_i) == SZ_BYTE) && dst_code_i[CW-1];
  assign tgt_idx = (size_e'(size_i) == SZ_BYTE) ? {1'b0, dst_code_i[CW-2:0]} : dst_code_i;

  gpr_view_wr #(.XLEN(XLEN)) u_merge (
    .old_i    (regs_q[tgt_idx]),
    .val_i    (alu_res),
    .size_i   (size_i),
    .hi_i     (hi_sel),
    .merged_o (merged)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[r] <= '0;
      else if (do_wr && tgt_idx == CW'(r))  regs_q[r] <= merged;
    end
  end
endmodule

// File: rtl/gpr_regfile_chk.sv
module gpr_regfile_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 8,
  localparam int unsigned CW = $clog2(NREG)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      we_i,
  input logic [1:0]                op_i,
  input logic [1:0]                size_i,
  input logic [CW-1:0]             dst_code_i,
  input logic                      illegal_o,
  input logic [1:0]                rd_a_size_i,
  input logic [XLEN-1:0]           rd_a_data_o,
  input logic [NREG-1:0][XLEN-1:0] regs_q
);
  logic ok;
  logic [CW-1:0] bidx;
  assign ok   = we_i && size_i != 2'd3 && op_i != 2'd3;
  assign bidx = {1'b0, dst_code_i[CW-2:0]};

  AST_WORD_KEEP_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && size_i == 2'd1 |=> regs_q[$past(dst_code_i)][XLEN-1:16] == $past(regs_q[dst_code_i][XLEN-1:16])); // R3
  AST_BYTE_LO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && size_i == 2'd0 && !dst_code_i[CW-1] |=> regs_q[$past(bidx)][XLEN-1:8] == $past(regs_q[bidx][XLEN-1:8])); // R4
  AST_BYTE_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && size_i == 2'd0 && dst_code_i[CW-1] |=> regs_q[$past(bidx)][XLEN-1:16] == $past(regs_q[bidx][XLEN-1:16])
      && regs_q[$past(bidx)][7:0] == $past(regs_q[bidx][7:0])); // R5
  AST_RD_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_size_i == 2'd0 |-> rd_a_data_o[XLEN-1:8] == '0); // R6
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> regs_q == $past(regs_q)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> regs_q == $past(regs_q)); // R10
  AST_IDLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> !illegal_o); // R10
endmodule

bind gpr_regfile_alias gpr_regfile_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .op_i        (op_i),
  .size_i      (size_i),
  .dst_code_i  (dst_code_i),
  .illegal_o   (illegal_o),
  .rd_a_size_i (rd_a_size_i),
  .rd_a_data_o (rd_a_data_o),
  .regs_q      (regs_q)
);

// File: tb/gpr_regfile_alias_tb.sv
`timescale 1ns/1ps
module gpr_regfile_alias_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0, use_imm = 1'b0;
  logic [1:0]  op = '0, size = '0, ra_size = 2'd2, rb_size = 2'd2;
  logic [2:0]  dst = '0, src = '0, ra_code = '0, rb_code = '0;
  logic [31:0] imm = '0;
  logic        illegal;
  logic [31:0] ra_data, rb_data;

  int checks = 0, errors = 0;
  logic [31:0] model [8];

  always #4 clk = ~clk;

  gpr_regfile_alias u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .op_i(op), .size_i(size),
    .dst_code_i(dst), .src_code_i(src), .use_imm_i(use_imm), .imm_i(imm),
    .illegal_o(illegal),
    .rd_a_code_i(ra_code), .rd_a_size_i(ra_size), .rd_a_data_o(ra_data),
    .rd_b_code_i(rb_code), .rd_b_size_i(rb_size), .rd_b_data_o(rb_data)
  );

  function automatic logic [31:0] mget(input logic [2:0] c, input logic [1:0] s);
    case (s)
      2'd0: mget = (c < 4) ? {24'h0, model[c][7:0]} : {24'h0, model[c-4][15:8]};
      2'd1: mget = {16'h0, model[c][15:0]};
      2'd2: mget = model[c];
      default: mget = 32'h0;
    endcase
  endfunction

  task automatic mput(input logic [2:0] c, input logic [1:0] s, input logic [31:0] v);
    case (s)
      2'd0: if (c < 4) model[c][7:0] = v[7:0]; else model[c-4][15:8] = v[7:0];
      2'd1: model[c][15:0] = v[15:0];
      2'd2: model[c] = v;
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check before posedge, update model at posedge
  task automatic step(input logic w, input logic [1:0] o, input logic [1:0] s,
                      input logic [2:0] d, input logic [2:0] sr, input logic ui,
                      input logic [31:0] im, input logic [2:0] ac, input logic [1:0] as_,
                      input logic [2:0] bc, input logic [1:0] bs, input string tag);
    logic lg;
    logic [31:0] a, b, r, m;
    @(negedge clk);
    we = w; op = o; size = s; dst = d; src = sr; use_imm = ui; imm = im;
    ra_code = ac; ra_size = as_; rb_code = bc; rb_size = bs;
    #1;
    lg = (s != 2'd3) && (o != 2'd3);
    chk({tag, " portA"}, ra_data, mget(ac, as_));
    chk({tag, " portB"}, rb_data, mget(bc, bs));
    chk({tag, " illegal"}, {31'h0, illegal}, {31'h0, w && !lg});
    @(posedge clk);
    if (w && lg) begin
      m = (s == 2'd0) ? 32'hff : (s == 2'd1) ? 32'hffff : 32'hffffffff;
      a = mget(d, s);
      b = ui ? (im & m) : mget(sr, s);
      r = (o == 2'd0) ? b : (o == 2'd1) ? a + b : a - b;
      mput(d, s, r & m);
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i += 2)
      step(1'b0, 2'd0, 2'd0, 3'd0, 3'd0, 1'b0, 32'h0, 3'(i), 2'd2, 3'(i + 1), 2'd2, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    sweep("R1 reset dword");
    step(1'b0, 0, 0, 0, 0, 0, 0, 3'd4, 2'd0, 3'd5, 2'd1, "R1 reset narrow");

    // R2 dword immediate loads
    for (int i = 0; i < 8; i++)
      step(1'b1, 2'd0, 2'd2, 3'(i), 3'd0, 1'b1, 32'h11223344 + 32'(i) * 32'h01010101,
           3'(i), 2'd2, 3'd0, 2'd0, "R2 dword load");
    sweep("R2 dword readback");

    // R3 word writes, including pointer registers
    step(1'b1, 2'd0, 2'd1, 3'd5, 3'd0, 1'b1, 32'hdeadbeef, 3'd5, 2'd2, 3'd5, 2'd1, "R3 word ptr");
    step(1'b1, 2'd0, 2'd1, 3'd2, 3'd0, 1'b1, 32'h0000a5a5, 3'd2, 2'd2, 3'd5, 2'd2, "R3 word data");
    // R4 / R5 byte writes
    step(1'b1, 2'd0, 2'd0, 3'd1, 3'd0, 1'b1, 32'hffffff77, 3'd1, 2'd2, 3'd2, 2'd2, "R4 low byte");
    step(1'b1, 2'd0, 2'd0, 3'd6, 3'd0, 1'b1, 32'h000000c3, 3'd2, 2'd2, 3'd6, 2'd0, "R5 high byte");
    // R7 read of the register being written returns old value
    step(1'b1, 2'd0, 2'd2, 3'd3, 3'd0, 1'b1, 32'hcafef00d, 3'd3, 2'd2, 3'd7, 2'd0, "R7 same-cycle");
    step(1'b0, 0, 0, 0, 0, 0, 0, 3'd3, 2'd2, 3'd3, 2'd1, "R7 after edge");
    sweep("R3 R4 R5 readback");

    // R8 moves at each size, hi->hi and lo->lo
    step(1'b1, 2'd0, 2'd0, 3'd7, 3'd4, 1'b0, 32'h0, 3'd3, 2'd2, 3'd0, 2'd2, "R8 mov hi-hi");
    step(1'b1, 2'd0, 2'd0, 3'd0, 3'd1, 1'b0, 32'h0, 3'd0, 2'd2, 3'd3, 2'd2, "R8 mov lo-lo");
    step(1'b1, 2'd0, 2'd1, 3'd6, 3'd2, 1'b0, 32'h0, 3'd6, 2'd2, 3'd0, 2'd2, "R8 mov word");
    step(1'b1, 2'd0, 2'd2, 3'd4, 3'd7, 1'b0, 32'h0, 3'd4, 2'd2, 3'd6, 2'd2, "R8 mov dword");
    // R8 wrapping arithmetic
    step(1'b1, 2'd0, 2'd2, 3'd0, 3'd0, 1'b1, 32'h1234f0f0, 3'd0, 2'd2, 3'd0, 2'd2, "R8 setup");
    step(1'b1, 2'd1, 2'd0, 3'd0, 3'd0, 1'b1, 32'h00000020, 3'd0, 2'd2, 3'd4, 2'd0, "R8 add imm wrap");
    step(1'b1, 2'd2, 2'd0, 3'd4, 3'd0, 1'b1, 32'h000000f5, 3'd0, 2'd2, 3'd0, 2'd0, "R8 sub imm wrap");
    step(1'b1, 2'd1, 2'd0, 3'd0, 3'd4, 1'b0, 32'h0, 3'd0, 2'd2, 3'd4, 2'd0, "R8 add alias hi");
    step(1'b1, 2'd1, 2'd1, 3'd5, 3'd0, 1'b1, 32'h0001ffff, 3'd5, 2'd2, 3'd0, 2'd2, "R8 add word");
    step(1'b1, 2'd2, 2'd2, 3'd1, 3'd3, 1'b0, 32'h0, 3'd1, 2'd2, 3'd3, 2'd2, "R8 sub dword");
    sweep("R8 readback");

    // R9 reserved size and op
    step(1'b1, 2'd0, 2'd3, 3'd2, 3'd0, 1'b1, 32'hffffffff, 3'd2, 2'd3, 3'd2, 2'd2, "R9 rsvd size");
    step(1'b1, 2'd3, 2'd2, 3'd2, 3'd0, 1'b1, 32'hffffffff, 3'd2, 2'd2, 3'd6, 2'd0, "R9 rsvd op");
    // R10 idle with busy operand inputs
    step(1'b0, 2'd1, 2'd2, 3'd2, 3'd2, 1'b1, 32'h55555555, 3'd2, 2'd2, 3'd2, 2'd1, "R10 idle");
    sweep("R9 R10 readback");

    // R6 mixed random operations and views
    for (int n = 0; n < 400; n++)
      step(1'($urandom), 2'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
           1'($urandom), $urandom, 3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom),
           "R6 R8 random");
    sweep("R6 final");
    finish_run();
  end
endmodule